// File: doc/BRIEF.md
# Shared AES State Holder (byte-serial)

This block stores the sixteen state bytes of a masked, byte-serial AES-128 datapath. Each byte is kept as `NSHARES` shares placed side by side. The bytes sit in a 4x4 grid of registers that is chained in row-major stream order. A plaintext loads as a valid sharing: share 0 carries the byte and every other share is zero. While the round runs, the head of the chain goes out one shared byte per cycle toward the S-box path, and the results come back in at the tail.

The block also does the two AES permutations on its own contents. ShiftRows takes one cycle through rotation muxes. MixColumns exchanges one whole column per cycle with an external share-wise MixColumns unit, so all four columns go round in four cycles. A stall mode freezes the chain while the S-box input is busy with a key byte. The final round skips MixColumns. Its last key addition reuses the shift mode and goes byte by byte over 16 cycles, with the external path bypassing the S-box. The ciphertext port stays at zero until the controller releases it.

Byte `i` of the AES state sits in row `i%4`, column `i/4`. Stream position `p = 4*row + col` gives the order 0,4,8,12,1,5,...,3,7,11,15. Share `s` of a shared byte occupies bits `[8*s +: 8]`.

Top module: `aes_share_state`

## Requirements
- R1: While `rst` is high and in the cycle after it, the state, `sb_out`, `mc_col_out` and `ct_out` are all zero.
- R2: With `mode`=1 (load), every byte `i` takes share 0 from `pt[8*i +: 8]`, and all its other shares become zero.
- R3: With `mode`=2 (shift), every stream position takes the byte of the next position, and `sb_in` enters position 15. `sb_out` is the byte at position 0, so after a load the bytes leave in the order 0,4,8,12,1,5,9,13,2,6,10,14,3,7,11,15.
- R4: With `mode`=3 (ShiftRows), row `r` rotates left by `r` in one cycle: the new byte at (r,c) is the old byte at (r,(c+r)%4).
- R5: `mc_col_out` carries column 0, with row `r` at bits `[r*8*NSHARES +: 8*NSHARES]`. With `mode`=4 (mix), column c takes column c+1, and column 3 takes `mc_col_in` with the same layout. After four mix cycles the column received first sits in column 0.
- R6: With `mode`=0, or with the unused codes 5 to 7, the whole state stays unchanged.
- R7: `ct_out` is zero in each cycle that follows a cycle with `release_ok` low. Otherwise it is a registered copy of the state, with share `s` of byte `i` at bits `[(i*NSHARES+s)*8 +: 8]`.
- R8: All shares of a byte follow the same route in every mode, so nonzero upper shares arriving on `sb_in` or `mc_col_in` keep their lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | 0 hold, 1 load, 2 shift, 3 ShiftRows, 4 mix |
| pt | input | 128 | Unshared plaintext, byte i at bits 8i+7:8i |
| sb_in | input | 8*NSHARES | Shared byte returning from the S-box path |
| mc_col_in | input | 32*NSHARES | Shared column returning from MixColumns |
| release_ok | input | 1 | Allows the ciphertext onto ct_out |
| sb_out | output | 8*NSHARES | Shared byte at stream position 0 |
| mc_col_out | output | 32*NSHARES | Shared column 0 sent to MixColumns |
| ct_out | output | 128*NSHARES | Gated shared state |

## Verification
The bench goes after the stream order on a plaintext whose bytes encode their own index. A chain wired column-major would emit 0,1,2,3 where 0,4,8,12 is required. It checks every row of a ShiftRows against a reference permutation, so a rotation by the wrong amount or in the wrong direction shows up as misplaced bytes in rows 1 to 3. Four mix cycles with distinct columns catch a column inserted at the wrong end. Unused mode codes must act like the stall, and nonzero upper shares catch lanes that get swapped or zeroed. Dropping `release_ok` must blank `ct_out`, so a design that leaks the shared state would be seen there.

// File: rtl/aes_state_pkg.sv
package aes_state_pkg;
  typedef enum logic [2:0] {
    M_HOLD  = 3'd0,
    M_LOAD  = 3'd1,
    M_SHIFT = 3'd2,
    M_SROW  = 3'd3,
    M_MIX   = 3'd4
  } st_mode_e;
endpackage

// File: rtl/aes_state_route.sv
module aes_state_route #(
  parameter int NSHARES = 2,
  parameter int BYTE_W  = 8,
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  localparam int BW     = BYTE_W * NSHARES,
  localparam int NB     = ROWS * COLS
) (
  input  logic [2:0]              mode,
  input  logic [NB-1:0][BW-1:0]   cur,
  input  logic [NB*BYTE_W-1:0]    pt,
  input  logic [BW-1:0]           sb_in,
  input  logic [ROWS*BW-1:0]      mc_in,
  output logic [NB-1:0][BW-1:0]   nxt
);
  import aes_state_pkg::*;

  for (genvar p = 0; p < NB; p++) begin : g_pos
    localparam int R    = p / COLS;
    localparam int C    = p % COLS;
    localparam int IDX  = R + ROWS * C;
    localparam int SRC  = R * COLS + ((C + R) % COLS);
    logic [BW-1:0] shift_src;
    logic [BW-1:0] mix_src;

    if (p == NB - 1) begin : g_tail
      assign shift_src = sb_in;
    end else begin : g_body
      assign shift_src = cur[p+1];
    end

    if (C == COLS - 1) begin : g_mcin
      assign mix_src = mc_in[R*BW +: BW];
    end else begin : g_mcmv
      assign mix_src = cur[p+1];
    end

    always_comb begin
      case (st_mode_e'(mode))
        M_LOAD:  nxt[p] = BW'(pt[IDX*BYTE_W +: BYTE_W]);
        M_SHIFT: nxt[p] = shift_src;
        M_SROW:  nxt[p] = cur[SRC];
        M_MIX:   nxt[p] = mix_src;
        default: nxt[p] = cur[p];
      endcase
    end
  end
endmodule

// File: rtl/aes_state_gate.sv
module aes_state_gate #(
  parameter int NSHARES = 2,
  parameter int BYTE_W  = 8,
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  localparam int BW     = BYTE_W * NSHARES,
  localparam int NB     = ROWS * COLS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  release_ok,
  input  logic [NB-1:0][BW-1:0] cur,
  output logic [NB*BW-1:0]      ct
);
  always_ff @(posedge clk) begin
    if (rst || !release_ok) begin
      ct <= '0;
    end else begin
      for (int p = 0; p < NB; p++) begin
        ct[((p / COLS) + ROWS * (p % COLS))*BW +: BW] <= cur[p];
      end
    end
  end
endmodule

// File: rtl/aes_share_state.sv
module aes_share_state #(
  parameter int NSHARES = 2,
  parameter int BYTE_W  = 8,
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  localparam int BW     = BYTE_W * NSHARES,
  localparam int NB     = ROWS * COLS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           mode,
  input  logic [NB*BYTE_W-1:0] pt,
  input  logic [BW-1:0]        sb_in,
  input  logic [ROWS*BW-1:0]   mc_col_in,
  input  logic                 release_ok,
  output logic [BW-1:0]        sb_out,
  output logic [ROWS*BW-1:0]   mc_col_out,
  output logic [NB*BW-1:0]     ct_out
);
  logic [NB-1:0][BW-1:0] st;
  logic [NB-1:0][BW-1:0] st_nxt;

  aes_state_route #(
    .NSHARES(NSHARES), .BYTE_W(BYTE_W), .ROWS(ROWS), .COLS(COLS)
  ) u_route (
    .mode  (mode),
    .cur   (st),
    .pt    (pt),
    .sb_in (sb_in),
    .mc_in (mc_col_in),
    .nxt   (st_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= st_nxt;
  end

  assign sb_out = st[0];

  for (genvar r = 0; r < ROWS; r++) begin : g_col0
    assign mc_col_out[r*BW +: BW] = st[r*COLS];
  end

  aes_state_gate #(
    .NSHARES(NSHARES), .BYTE_W(BYTE_W), .ROWS(ROWS), .COLS(COLS)
  ) u_gate (
    .clk        (clk),
    .rst        (rst),
    .release_ok (release_ok),
    .cur        (st),
    .ct         (ct_out)
  );
endmodule

// File: rtl/aes_state_chk.sv
module aes_state_chk #(
  parameter int NSHARES = 2,
  parameter int BYTE_W  = 8,
  localparam int BW     = BYTE_W * NSHARES,
  localparam int NB     = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2:0]            mode,
  input logic [BYTE_W-1:0]     pt_b4,
  input logic [BW-1:0]         sb_in,
  input logic [BW-1:0]         mc_b0,
  input logic [BW-1:0]         mc_b3,
  input logic                  release_ok,
  input logic [NB-1:0][BW-1:0] st,
  input logic [NB*BW-1:0]      ct_out
);
  // R2: byte 4 sits at stream position 1
  a_r2_load_share: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd1 |=> st[1] == BW'($past(pt_b4)));

  // R3: the returning byte lands at the tail
  a_r3_shift_tail: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd2 |=> st[NB-1] == $past(sb_in));

  // R4: rows 1..3 rotate, row 0 keeps its place
  a_r4_rot_rows: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd3 |=> (st[4] == $past(st[5])) && (st[8] == $past(st[10]))
                     && (st[12] == $past(st[15])) && (st[0] == $past(st[0])));

  // R5: incoming column enters column 3
  a_r5_mix_in: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd4 |=> (st[3] == $past(mc_b0)) && (st[15] == $past(mc_b3)));

  // R6: hold and unused codes freeze the chain
  a_r6_stall: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 || mode > 3'd4) |=> $stable(st));

  // R7: gated ciphertext
  a_r7_gate_low: assert property (@(posedge clk) disable iff (rst)
    !release_ok |=> ct_out == '0);

  a_r7_gate_copy: assert property (@(posedge clk) disable iff (rst)
    release_ok |=> ct_out[BW-1:0] == $past(st[0]));
endmodule

bind aes_share_state aes_state_chk #(.NSHARES(NSHARES), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .pt_b4      (pt[4*BYTE_W +: BYTE_W]),
  .sb_in      (sb_in),
  .mc_b0      (mc_col_in[BW-1:0]),
  .mc_b3      (mc_col_in[4*BW-1:3*BW]),
  .release_ok (release_ok),
  .st         (st),
  .ct_out     (ct_out)
);

// File: tb/aes_share_state_tb.sv
module aes_share_state_tb;
  localparam int D   = 2;
  localparam int BW  = 8 * D;
  localparam int CTW = 16 * BW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mode = 3'd0;
  logic [127:0] pt = '0;
  logic [BW-1:0] sb_in = '0;
  logic [4*BW-1:0] mc_col_in = '0;
  logic release_ok = 1'b1;
  logic [BW-1:0] sb_out;
  logic [4*BW-1:0] mc_col_out;
  logic [CTW-1:0] ct_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit ended = 0;

  logic [BW-1:0] m [16];

  always #10 clk = ~clk;

  aes_share_state #(.NSHARES(D)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .pt(pt), .sb_in(sb_in),
    .mc_col_in(mc_col_in), .release_ok(release_ok),
    .sb_out(sb_out), .mc_col_out(mc_col_out), .ct_out(ct_out)
  );

  localparam logic [2:0] OPS [14] = '{3'd1, 3'd2, 3'd2, 3'd3, 3'd4, 3'd4, 3'd2,
                                      3'd0, 3'd6, 3'd3, 3'd4, 3'd4, 3'd2, 3'd1};

  task automatic chk(input string tag, input logic [CTW-1:0] act, input logic [CTW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [CTW-1:0] exp_ct();
    logic [CTW-1:0] v = '0;
    for (int p = 0; p < 16; p++) v[((p / 4) + 4 * (p % 4))*BW +: BW] = m[p];
    return v;
  endfunction

  function automatic logic [4*BW-1:0] exp_col();
    logic [4*BW-1:0] v;
    for (int r = 0; r < 4; r++) v[r*BW +: BW] = m[4*r];
    return v;
  endfunction

  function automatic string tag_of(input logic [2:0] md);
    case (md)
      3'd1: return "R2 R8";
      3'd2: return "R3 R8";
      3'd3: return "R4 R8";
      3'd4: return "R5 R8";
      default: return "R6";
    endcase
  endfunction

  task automatic model(input logic [2:0] md);
    logic [BW-1:0] t [16];
    for (int p = 0; p < 16; p++) t[p] = m[p];
    for (int p = 0; p < 16; p++) begin
      int r = p / 4;
      int c = p % 4;
      case (md)
        3'd1: m[p] = BW'(pt[8*(r + 4*c) +: 8]);
        3'd2: m[p] = (p == 15) ? sb_in : t[p+1];
        3'd3: m[p] = t[4*r + (c + r) % 4];
        3'd4: m[p] = (c == 3) ? mc_col_in[r*BW +: BW] : t[p+1];
        default: m[p] = t[p];
      endcase
    end
  endtask

  task automatic op(input logic [2:0] md);
    @(negedge clk);
    mode = md;
    model(md);
    @(negedge clk);
    mode = 3'd0;
    @(negedge clk);
  endtask

  task automatic verify(input string tag);
    chk({tag, " state"}, ct_out, exp_ct());
    chk({tag, " head"}, CTW'(sb_out), CTW'(m[0]));
    chk({tag, " col0"}, CTW'(mc_col_out), CTW'(exp_col()));
  endtask

  task automatic set_data(input int k);
    for (int s = 0; s < D; s++) sb_in[8*s +: 8] = 8'(k*29 + s*71 + 3);
    for (int b = 0; b < 4*D; b++) mc_col_in[8*b +: 8] = 8'(k*41 + b*13 + 7);
    for (int b = 0; b < 16; b++) pt[8*b +: 8] = 8'(b*17 + k*5 + 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 16; p++) m[p] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 ct", ct_out, '0);
    chk("R1 head", CTW'(sb_out), '0);
    chk("R1 col0", CTW'(mc_col_out), '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after", ct_out, '0);

    // table walk
    for (int k = 0; k < 14; k++) begin
      set_data(k);
      op(OPS[k]);
      verify(tag_of(OPS[k]));
    end

    // R3: stream order from a self-indexing plaintext
    for (int b = 0; b < 16; b++) pt[8*b +: 8] = 8'(8'h40 + b);
    op(3'd1);
    verify("R2 R8");
    for (int k = 0; k < 16; k++) begin
      chk("R3 order", CTW'(sb_out), CTW'(8'(8'h40 + (k / 4) + 4 * (k % 4))));
      for (int s = 0; s < D; s++) sb_in[8*s +: 8] = 8'(k + 16*s + 8'h90);
      op(3'd2);
    end
    verify("R3 R8");

    // R5: four distinct columns, the first arrives at column 0
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 4*D; b++) mc_col_in[8*b +: 8] = 8'(8'hA0 + 16*k + b);
      op(3'd4);
    end
    for (int b = 0; b < 4*D; b++)
      chk("R5 first column", CTW'(mc_col_out[8*b +: 8]), CTW'(8'(8'hA0 + b)));
    verify("R5 R8");

    // R6: unused codes act as stall
    op(3'd7);
    verify("R6");
    op(3'd5);
    verify("R6");

    // R7: gating
    @(negedge clk);
    release_ok = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 gated", ct_out, '0);
    release_ok = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 released", ct_out, exp_ct());

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule